// File: doc/BRIEF.md
# Keyed Configuration Write Guard

This block sits in front of a bank of clock-configuration registers on a simple synchronous register bus and blocks any one-shot stray write to them. Software has to write a key word to a dedicated unlock register before each update of a guarded register. The key word carries a fixed key byte and the byte offset of the register to be opened. The very next bus write is then judged. It is accepted only if it targets that exact offset. Either way, the permission is used up.

The block holds six guarded configuration words and a row of generic clock control words. The generic words are written directly, with no key. It also has a status word built from four external ready/lock inputs, a sticky error flag for rejected writes, and a one-cycle synchronisation request pulse. Each register write that lands raises a one-cycle strobe for that register, so downstream clock logic can pick up the new value.

Top module: `keyed_cfg_gate`

## Requirements
- R1: A write to offset 0x18 whose bits 31:24 equal 0xAA arms a single pending permission for the offset given in bits 7:0 of the written word. Bits 23:8 are ignored.
- R2: The guarded registers sit at 0x20, 0x24, 0x28, 0x30, 0x34 and 0x38, and their strobe indices are 0 to 5 in that order. A write to one of them is accepted when the immediately preceding bus write armed a permission for that same offset. On acceptance the register takes the written word, and its bit of `cfg_wr_stb` is high for exactly the one cycle after the accepting clock edge.
- R3: Every bus write clears a pending permission, whatever address it targets, unless it is itself a valid key write. A second write to an opened register therefore needs a new key.
- R4: A write to 0x18 whose bits 31:24 differ from 0xAA arms nothing and also cancels any permission that is already pending.
- R5: A rejected write to a guarded register leaves its contents unchanged and raises no strobe. It sets `err_flag`, which stays high until it is cleared.
- R6: Writing a word with bit 0 set to offset 0x10 clears `err_flag`. A write there with bit 0 clear has no effect on the flag. Reading 0x10 returns the flag in bit 0.
- R7: Reading 0x14 returns `status_in[0]` in bit 0, `status_in[1]` in bit 2, `status_in[2]` in bit 3 and `status_in[3]` in bit 6. All other bits read as zero.
- R8: Reading 0x18 returns zero. Reading a guarded register returns its current contents. Reading an unmapped offset returns zero.
- R9: The generic clock words at 0x74 + 4k, for k = 0 to 11, take any write directly. Bit k of `gen_wr_stb` is high for the one cycle after the write. An offset past the last word is unmapped.
- R10: A write to 0x40 with bit 0 set raises `sync_pulse` for the one cycle after the edge. A write there with bit 0 clear does not raise it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per high cycle |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| status_in | input | 4 | Oscillator ready, DFLL locked, DFLL synchronised, PLL locked |
| cfg_wr_stb | output | 6 | One-cycle strobe per guarded register update |
| gen_wr_stb | output | 12 | One-cycle strobe per generic clock word update |
| sync_pulse | output | 1 | One-cycle synchronisation request |
| err_flag | output | 1 | Sticky rejected-write flag |

## Verification
The guard is exercised with several key-and-write sequences. The first is a matching key followed directly by its write, which separates a working accept path from a dead one. A key for one offset followed by a write to another shows whether the offset is really compared. A valid key followed by an unrelated write and only then the target write shows whether the permission is consumed by any write, not just by matching ones. A wrong key byte, including one written on top of a valid pending key, shows that only the exact key arms the guard and that a bad key also disarms it. A repeated write after one accepted update shows that the permission is single-use. Status reads with complementary input patterns tell a correct bit mapping from a shifted or swapped one.

// File: rtl/cfgkey_pkg.sv
package cfgkey_pkg;

    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 32;
    localparam int KEY_W      = 8;
    localparam int N_PROT     = 6;
    localparam int N_GEN      = 12;
    localparam int N_STAT     = 4;
    localparam int PROT_IDX_W = $clog2(N_PROT);
    localparam int GEN_IDX_W  = $clog2(N_GEN);

    localparam logic [ADDR_W-1:0] OFF_ERRCLR   = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_STATUS   = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_UNLOCK   = 8'h18;
    localparam logic [ADDR_W-1:0] OFF_SYNC     = 8'h40;
    localparam logic [ADDR_W-1:0] OFF_GEN_BASE = 8'h74;
    localparam logic [KEY_W-1:0]  KEY_BYTE     = 8'hAA;

    localparam logic [ADDR_W-1:0] PROT_OFF [N_PROT] =
        '{8'h20, 8'h24, 8'h28, 8'h30, 8'h34, 8'h38};

    // Bit position of each status input inside the status word
    localparam int STAT_POS [N_STAT] = '{0, 2, 3, 6};

    typedef struct packed {
        logic                  hit;
        logic [PROT_IDX_W-1:0] idx;
    } prot_dec_t;

    typedef struct packed {
        logic                 hit;
        logic [GEN_IDX_W-1:0] idx;
    } gen_dec_t;

    function automatic prot_dec_t prot_decode(input logic [ADDR_W-1:0] a);
        prot_dec_t d;
        d = '0;
        for (int i = 0; i < N_PROT; i++) begin
            if (a == PROT_OFF[i]) begin
                d.hit = 1'b1;
                d.idx = PROT_IDX_W'(i);
            end
        end
        return d;
    endfunction

    function automatic gen_dec_t gen_decode(input logic [ADDR_W-1:0] a);
        gen_dec_t          d;
        logic [ADDR_W-1:0] rel;
        rel   = a - OFF_GEN_BASE;
        d.hit = (a >= OFF_GEN_BASE) && (rel[1:0] == 2'b00)
                && (int'(rel[ADDR_W-1:2]) < N_GEN);
        d.idx = GEN_IDX_W'(rel[ADDR_W-1:2]);
        return d;
    endfunction

    function automatic logic [DATA_W-1:0] status_word(input logic [N_STAT-1:0] s);
        logic [DATA_W-1:0] w;
        w = '0;
        for (int i = 0; i < N_STAT; i++) begin
            w[STAT_POS[i]] = s[i];
        end
        return w;
    endfunction

endpackage

// File: rtl/cfg_unlock_ctl.sv
module cfg_unlock_ctl
    import cfgkey_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [KEY_W-1:0]  key_in,
    input  logic [ADDR_W-1:0] tgt_in,
    input  logic              clr_bit,
    input  prot_dec_t         pdec,
    output logic              accept,
    output logic              pend_vld,
    output logic              err_flag
);

    logic [ADDR_W-1:0] pend_off;
    logic              key_ok;
    logic              reject;

    assign key_ok = we && (addr == OFF_UNLOCK) && (key_in == KEY_BYTE);
    assign accept = we && pdec.hit && pend_vld && (pend_off == addr);
    assign reject = we && pdec.hit && !accept;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_vld <= 1'b0;
            pend_off <= '0;
        end else if (we) begin
            pend_vld <= key_ok;
            if (key_ok) begin
                pend_off <= tgt_in;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_flag <= 1'b0;
        end else if (reject) begin
            err_flag <= 1'b1;
        end else if (we && (addr == OFF_ERRCLR) && clr_bit) begin
            err_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/cfg_reg_store.sv
module cfg_reg_store
    import cfgkey_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          we,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [DATA_W-1:0]             wdata,
    input  logic                          accept,
    input  prot_dec_t                     pdec,
    input  gen_dec_t                      gdec,
    output logic [N_PROT-1:0][DATA_W-1:0] prot_q,
    output logic [N_GEN-1:0][DATA_W-1:0]  gen_q,
    output logic [N_PROT-1:0]             prot_stb,
    output logic [N_GEN-1:0]              gen_stb,
    output logic                          sync_pulse
);

    for (genvar i = 0; i < N_PROT; i++) begin : g_prot
        logic sel;
        assign sel = accept && (pdec.idx == PROT_IDX_W'(i));
        always_ff @(posedge clk) begin
            if (rst) begin
                prot_q[i]   <= '0;
                prot_stb[i] <= 1'b0;
            end else begin
                prot_stb[i] <= sel;
                if (sel) begin
                    prot_q[i] <= wdata;
                end
            end
        end
    end

    for (genvar k = 0; k < N_GEN; k++) begin : g_gen
        logic sel;
        assign sel = we && gdec.hit && (gdec.idx == GEN_IDX_W'(k));
        always_ff @(posedge clk) begin
            if (rst) begin
                gen_q[k]   <= '0;
                gen_stb[k] <= 1'b0;
            end else begin
                gen_stb[k] <= sel;
                if (sel) begin
                    gen_q[k] <= wdata;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_pulse <= 1'b0;
        end else begin
            sync_pulse <= we && (addr == OFF_SYNC) && wdata[0];
        end
    end

endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
    import cfgkey_pkg::*;
(
    input  logic [ADDR_W-1:0]             addr,
    input  prot_dec_t                     pdec,
    input  gen_dec_t                      gdec,
    input  logic [N_PROT-1:0][DATA_W-1:0] prot_q,
    input  logic [N_GEN-1:0][DATA_W-1:0]  gen_q,
    input  logic [N_STAT-1:0]             status_in,
    input  logic                          err_flag,
    output logic [DATA_W-1:0]             rdata
);

    always_comb begin
        rdata = '0;
        if (pdec.hit) begin
            rdata = prot_q[pdec.idx];
        end else if (gdec.hit) begin
            rdata = gen_q[gdec.idx];
        end else begin
            case (addr)
                OFF_STATUS: rdata = status_word(status_in);
                OFF_ERRCLR: rdata = {{(DATA_W-1){1'b0}}, err_flag};
                default:    rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/keyed_cfg_gate.sv
module keyed_cfg_gate
    import cfgkey_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_we,
    output logic [31:0]       bus_rdata,
    input  logic [3:0]        status_in,
    output logic [5:0]        cfg_wr_stb,
    output logic [11:0]       gen_wr_stb,
    output logic              sync_pulse,
    output logic              err_flag
);

    prot_dec_t                     pdec;
    gen_dec_t                      gdec;
    logic                          accept;
    logic                          pend_vld;
    logic [N_PROT-1:0][DATA_W-1:0] prot_q;
    logic [N_GEN-1:0][DATA_W-1:0]  gen_q;

    assign pdec = prot_decode(bus_addr);
    assign gdec = gen_decode(bus_addr);

    cfg_unlock_ctl u_unlock (
        .clk      (clk),
        .rst      (rst),
        .we       (bus_we),
        .addr     (bus_addr),
        .key_in   (bus_wdata[DATA_W-1 -: KEY_W]),
        .tgt_in   (bus_wdata[ADDR_W-1:0]),
        .clr_bit  (bus_wdata[0]),
        .pdec     (pdec),
        .accept   (accept),
        .pend_vld (pend_vld),
        .err_flag (err_flag)
    );

    cfg_reg_store u_store (
        .clk        (clk),
        .rst        (rst),
        .we         (bus_we),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .accept     (accept),
        .pdec       (pdec),
        .gdec       (gdec),
        .prot_q     (prot_q),
        .gen_q      (gen_q),
        .prot_stb   (cfg_wr_stb),
        .gen_stb    (gen_wr_stb),
        .sync_pulse (sync_pulse)
    );

    cfg_read_mux u_rd (
        .addr      (bus_addr),
        .pdec      (pdec),
        .gdec      (gdec),
        .prot_q    (prot_q),
        .gen_q     (gen_q),
        .status_in (status_in),
        .err_flag  (err_flag),
        .rdata     (bus_rdata)
    );

endmodule

// File: rtl/cfg_gate_checker.sv
module cfg_gate_checker
    import cfgkey_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [KEY_W-1:0]  key_byte,
    input logic              wbit0,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [N_STAT-1:0] status_in,
    input logic [N_PROT-1:0] cfg_wr_stb,
    input logic              err_flag,
    input logic              pend_vld
);

    logic good_key;
    logic prot_hit;
    assign good_key = bus_we && (bus_addr == OFF_UNLOCK) && (key_byte == KEY_BYTE);
    assign prot_hit = prot_decode(bus_addr).hit;

    AST_KEY_ARMS: assert property (@(posedge clk) disable iff (rst)
        good_key |=> pend_vld); // R1

    AST_STB_NEEDS_KEY: assert property (@(posedge clk) disable iff (rst)
        (|cfg_wr_stb) |-> ($past(pend_vld) && $past(bus_we))); // R2

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cfg_wr_stb)); // R2

    AST_WRITE_CONSUMES: assert property (@(posedge clk) disable iff (rst)
        (bus_we && !good_key) |=> !pend_vld); // R3

    AST_BAD_KEY_DISARMS: assert property (@(posedge clk) disable iff (rst)
        (bus_we && (bus_addr == OFF_UNLOCK) && (key_byte != KEY_BYTE)) |=> !pend_vld); // R4

    AST_REJECT_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (bus_we && prot_hit && !pend_vld) |=> (err_flag && (cfg_wr_stb == '0))); // R5

    AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (bus_we && (bus_addr == OFF_ERRCLR) && wbit0) |=> !err_flag); // R6

    AST_STATUS_MAP: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == OFF_STATUS) |-> (bus_rdata[0] == status_in[0] && bus_rdata[2] == status_in[1]
                                      && bus_rdata[3] == status_in[2] && bus_rdata[6] == status_in[3])); // R7

    AST_UNLOCK_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == OFF_UNLOCK) |-> (bus_rdata == '0)); // R8

endmodule

bind keyed_cfg_gate cfg_gate_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .key_byte   (bus_wdata[31:24]),
    .wbit0      (bus_wdata[0]),
    .bus_we     (bus_we),
    .bus_rdata  (bus_rdata),
    .status_in  (status_in),
    .cfg_wr_stb (cfg_wr_stb),
    .err_flag   (err_flag),
    .pend_vld   (pend_vld)
);

// File: tb/tb_keyed_cfg_gate.sv
module tb_keyed_cfg_gate;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic [3:0]  status_in = '0;
    logic [5:0]  cfg_wr_stb;
    logic [11:0] gen_wr_stb;
    logic        sync_pulse;
    logic        err_flag;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    keyed_cfg_gate dut (
        .clk        (clk),
        .rst        (rst),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_we     (bus_we),
        .bus_rdata  (bus_rdata),
        .status_in  (status_in),
        .cfg_wr_stb (cfg_wr_stb),
        .gen_wr_stb (gen_wr_stb),
        .sync_pulse (sync_pulse),
        .err_flag   (err_flag)
    );

    typedef struct packed {
        logic        rd;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VEC [NV] = '{
        {1'b0, 8'h18, 32'hAA000020, 8'd1},
        {1'b0, 8'h20, 32'h11111111, 8'd2},
        {1'b1, 8'h20, 32'h11111111, 8'd2},
        {1'b0, 8'h24, 32'h22222222, 8'd5},
        {1'b1, 8'h24, 32'h00000000, 8'd5},
        {1'b0, 8'h18, 32'hAA000028, 8'd3},
        {1'b0, 8'h24, 32'h33333333, 8'd3},
        {1'b1, 8'h24, 32'h00000000, 8'd3},
        {1'b1, 8'h28, 32'h00000000, 8'd3},
        {1'b0, 8'h18, 32'hAA000028, 8'd3},
        {1'b0, 8'h74, 32'h00000055, 8'd9},
        {1'b0, 8'h28, 32'h44444444, 8'd3},
        {1'b1, 8'h28, 32'h00000000, 8'd3},
        {1'b1, 8'h74, 32'h00000055, 8'd9},
        {1'b0, 8'h18, 32'hAB000030, 8'd4},
        {1'b0, 8'h30, 32'h66666666, 8'd4},
        {1'b1, 8'h30, 32'h00000000, 8'd4},
        {1'b0, 8'h18, 32'hAA000030, 8'd4},
        {1'b0, 8'h18, 32'h55000030, 8'd4},
        {1'b0, 8'h30, 32'h77777777, 8'd4},
        {1'b1, 8'h30, 32'h00000000, 8'd4},
        {1'b0, 8'h18, 32'hAA000030, 8'd3},
        {1'b0, 8'h30, 32'h88888888, 8'd2},
        {1'b1, 8'h30, 32'h88888888, 8'd2},
        {1'b0, 8'h30, 32'h99999999, 8'd3},
        {1'b1, 8'h30, 32'h88888888, 8'd3},
        {1'b0, 8'h18, 32'hAA123434, 8'd1},
        {1'b0, 8'h34, 32'h00001234, 8'd1},
        {1'b1, 8'h34, 32'h00001234, 8'd1},
        {1'b1, 8'h18, 32'h00000000, 8'd8},
        {1'b1, 8'h3C, 32'h00000000, 8'd8},
        {1'b1, 8'h20, 32'h11111111, 8'd8}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Write ends at the following falling edge; strobes of this write are visible then
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [31:0] r;
        do_reset();

        // Reset state
        rd(8'h20, r);
        check("R8 reset contents", r, 32'h0);
        check("R5 reset err_flag", {31'b0, err_flag}, 32'h0);
        check("R2 reset strobes", {26'b0, cfg_wr_stb}, 32'h0);
        check("R10 reset sync", {31'b0, sync_pulse}, 32'h0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            if (VEC[i].rd) begin
                rd(VEC[i].addr, r);
                check($sformatf("R%0d vec%0d", VEC[i].req, i), r, VEC[i].data);
            end else begin
                wr(VEC[i].addr, VEC[i].data);
            end
        end

        // R5 and R6: sticky flag and its clear
        check("R5 err sticky after rejects", {31'b0, err_flag}, 32'h1);
        rd(8'h10, r);
        check("R6 err readback", r, 32'h1);
        wr(8'h10, 32'h0000_0002);
        check("R6 clear with bit0 low keeps flag", {31'b0, err_flag}, 32'h1);
        wr(8'h10, 32'h0000_0001);
        check("R6 clear with bit0 high", {31'b0, err_flag}, 32'h0);
        rd(8'h10, r);
        check("R6 readback after clear", r, 32'h0);

        // R2: strobe timing on an accepted write
        wr(8'h18, 32'hAA000024);
        wr(8'h24, 32'hCAFE0001);
        check("R2 strobe index 1", {26'b0, cfg_wr_stb}, 32'h2);
        check("R2 no error on accept", {31'b0, err_flag}, 32'h0);
        @(negedge clk);
        check("R2 strobe one cycle", {26'b0, cfg_wr_stb}, 32'h0);
        wr(8'h18, 32'hAA000038);
        wr(8'h38, 32'h0000BEEF);
        check("R2 strobe index 5", {26'b0, cfg_wr_stb}, 32'h20);

        // R5: rejected write gives no strobe and sets flag
        wr(8'h24, 32'hDEAD0000);
        check("R5 no strobe on reject", {26'b0, cfg_wr_stb}, 32'h0);
        check("R5 flag on reject", {31'b0, err_flag}, 32'h1);
        rd(8'h24, r);
        check("R5 contents kept", r, 32'hCAFE0001);

        // R7: status mapping
        status_in = 4'b0101;
        rd(8'h14, r);
        check("R7 status 0101", r, 32'h0000_0009);
        status_in = 4'b1010;
        rd(8'h14, r);
        check("R7 status 1010", r, 32'h0000_0044);
        status_in = 4'b1111;
        rd(8'h14, r);
        check("R7 status 1111", r, 32'h0000_004D);

        // R9: generic words
        wr(8'h80, 32'h0000_0D01);
        check("R9 gen strobe k3", {20'b0, gen_wr_stb}, 32'h0000_0008);
        rd(8'h80, r);
        check("R9 gen readback", r, 32'h0000_0D01);
        wr(8'hA0, 32'h0000_00A0);
        check("R9 gen strobe k11", {20'b0, gen_wr_stb}, 32'h0000_0800);
        wr(8'hA4, 32'h1234_5678);
        check("R9 past last word no strobe", {20'b0, gen_wr_stb}, 32'h0);
        rd(8'hA4, r);
        check("R9 past last word unmapped", r, 32'h0);

        // R10: sync request
        wr(8'h40, 32'h0000_0001);
        check("R10 sync pulse", {31'b0, sync_pulse}, 32'h1);
        @(negedge clk);
        check("R10 sync one cycle", {31'b0, sync_pulse}, 32'h0);
        wr(8'h40, 32'h0000_0002);
        check("R10 bit0 low no pulse", {31'b0, sync_pulse}, 32'h0);

        // Reset mid-run clears contents
        do_reset();
        rd(8'h30, r);
        check("R8 contents after reset", r, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule